// File: doc/BRIEF.md
# Four-Channel DAC Command Register Bank

This block is the digital control core of a four-channel, 16-bit digital-to-analog converter. A serial bus slave in front of it hands over complete 24-bit command words, each marked by a single-cycle valid pulse. The block decodes each word and keeps the DAC state: a staging (input) register and an active (DAC) register per channel, a per-channel power-down mode, a load-mask register and an internal-reference enable.

The four active codes, the power-down modes and the reference enable drive the analog side. Staged values move to the active registers in one of three ways: by command, by write-through while the load strobe is held low, or by a falling edge of the active-low hardware load input. A mask register can exclude any channel from the strobe.

Every state change becomes visible in the cycle after the clock edge that samples the frame or strobe. The frame acknowledge pulse appears in that same cycle.

Top module: `dac_cmd_bank`

## Requirements
- R1: A frame holds the command in bits [23:20], the channel selection in bits [19:16] (bit 16 = channel A, 17 = B, 18 = C, 19 = D) and the data in bits [15:0]. Any set of channels may be selected, and each selected channel receives the same action.
- R2: Command 0000 and commands 1000 through 1111 leave every code, power-down mode, mask bit and the reference enable unchanged.
- R3: Command 0001 writes the data into the staging register of each selected channel. The active code of that channel takes the data in the same step only when `ldac_n` is low and the channel's mask bit is 0. Otherwise the active code holds.
- R4: Command 0010 copies the staging register of each selected channel into its active code.
- R5: Command 0011 writes the data into both the staging register and the active code of each selected channel.
- R6: A high-to-low transition of `ldac_n`, as seen on two successive clock edges, copies staging into active for every channel whose mask bit is 0, whatever the selection. Masked channels ignore it. When no frame arrives and there is no such transition, the active codes hold.
- R7: Command 0101 loads the mask register from data bits [3:0], with bit i belonging to channel i (0 = A). A mask bit of 1 makes the channel ignore both the load strobe and write-through.
- R8: Command 0100 sets the power-down mode of each selected channel from data bits [2i+1:2i] for channel i. Unselected channels keep their mode. A mode of 00 means normal operation and any other value means powered down.
- R9: Command 0111 sets `ref_en` to the inverse of data bit 0, so 0 enables the reference and 1 disables it.
- R10: A low `rst_n` at a clock edge, or command 0110, puts every staging register and active code at 0x0000 when `rst_mid` is 0, or at 0x8000 when it is 1. The same reset clears all power-down modes to 00, clears the mask to 0 and sets `ref_en` to 1.
- R11: `frame_ack` is high for exactly the one cycle after a frame with a command from 0001 to 0111. It stays low after no-op frames, after reserved frames, and when no frame arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, sampled synchronously |
| rst_mid | input | 1 | Reset value select: 0 gives zero code, 1 gives midscale |
| frame_valid | input | 1 | One-cycle pulse marking a complete frame |
| frame_word | input | 24 | Command, channel selection and data |
| ldac_n | input | 1 | Active-low hardware load strobe |
| frame_ack | output | 1 | One-cycle acknowledge of an accepted frame |
| dac_code | output | 4x16 | Active code per channel, index 0 = channel A |
| pd_mode | output | 4x2 | Power-down mode per channel |
| ref_en | output | 1 | Internal reference enable |

## Verification
The bench sweeps every command against every channel-selection pattern while moving the load strobe and the reset value select. A decoder that wired the selection bits in the wrong order, or that let a reserved code through, would change the wrong channels or states. The mask corner writes every channel with the strobe held low and then with a fresh falling edge, while two channels are masked. A design that ignored the mask, or treated the strobe as a level, would move the masked codes or copy on every cycle. Software and hardware reset are each run with both reset values, which catches a midscale bit in the wrong place or a reference left disabled.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  typedef logic [3:0] cmd_t;

  localparam cmd_t CMD_NOP    = 4'h0;
  localparam cmd_t CMD_WR_IN  = 4'h1;
  localparam cmd_t CMD_UPD    = 4'h2;
  localparam cmd_t CMD_WR_UPD = 4'h3;
  localparam cmd_t CMD_PWR    = 4'h4;
  localparam cmd_t CMD_MASK   = 4'h5;
  localparam cmd_t CMD_SRST   = 4'h6;
  localparam cmd_t CMD_REF    = 4'h7;

  // one-hot action strobes produced from a command code
  typedef struct packed {
    logic wr_in;
    logic upd;
    logic wr_upd;
    logic pwr;
    logic mask;
    logic srst;
    logic refc;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input cmd_t c);
    cmd_dec_t d;
    d = '0;
    case (c)
      CMD_WR_IN:  d.wr_in  = 1'b1;
      CMD_UPD:    d.upd    = 1'b1;
      CMD_WR_UPD: d.wr_upd = 1'b1;
      CMD_PWR:    d.pwr    = 1'b1;
      CMD_MASK:   d.mask   = 1'b1;
      CMD_SRST:   d.srst   = 1'b1;
      CMD_REF:    d.refc   = 1'b1;
      default:    d        = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/dac_frame_decode.sv
module dac_frame_decode
  import dac_cmd_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 16,
  localparam int FRAME_W = 4 + NUM_CH + CODE_W
) (
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_word,
  output cmd_dec_t           dec,
  output logic [NUM_CH-1:0]  sel,
  output logic [CODE_W-1:0]  data
);

  always_comb begin
    dec  = frame_valid ? decode_cmd(frame_word[FRAME_W-1 -: 4]) : '0;
    sel  = frame_word[CODE_W +: NUM_CH];
    data = frame_word[CODE_W-1:0];
  end

endmodule

// File: rtl/dac_chan_slot.sv
module dac_chan_slot #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] rst_code,
  input  logic              srst,
  input  logic              sel,
  input  logic              wr_in,
  input  logic              upd,
  input  logic              wr_upd,
  input  logic              pwr,
  input  logic [1:0]        pd_bits,
  input  logic [CODE_W-1:0] data,
  input  logic              masked,
  input  logic              ldac_low,
  input  logic              ldac_fall,
  output logic [CODE_W-1:0] in_q,
  output logic [CODE_W-1:0] dac_q,
  output logic [1:0]        pd_q
);

  logic [CODE_W-1:0] in_next;
  logic              load;

  always_comb begin
    in_next = (sel && (wr_in || wr_upd)) ? data : in_q;
    load    = (sel && (upd || wr_upd))
           || (sel && wr_in && ldac_low && !masked)
           || (ldac_fall && !masked);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      in_q  <= rst_code;
      dac_q <= rst_code;
      pd_q  <= 2'b00;
    end else begin
      in_q <= in_next;
      if (load)       dac_q <= in_next;
      if (sel && pwr) pd_q  <= pd_bits;
    end
  end

endmodule

// File: rtl/dac_cmd_bank.sv
module dac_cmd_bank
  import dac_cmd_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 16,
  localparam int FRAME_W = 4 + NUM_CH + CODE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rst_mid,
  input  logic                          frame_valid,
  input  logic [FRAME_W-1:0]            frame_word,
  input  logic                          ldac_n,
  output logic                          frame_ack,
  output logic [NUM_CH-1:0][CODE_W-1:0] dac_code,
  output logic [NUM_CH-1:0][1:0]        pd_mode,
  output logic                          ref_en
);

  function automatic logic [CODE_W-1:0] reset_code(input logic mid);
    logic [CODE_W-1:0] r;
    r = '0;
    r[CODE_W-1] = mid;
    return r;
  endfunction

  cmd_dec_t          dec;
  logic [NUM_CH-1:0] sel;
  logic [CODE_W-1:0] data;
  logic [NUM_CH-1:0] mask_q;
  logic              ldac_q;
  logic              ldac_fall;
  logic              frame_hit;
  logic              soft_rst_evt;
  logic [CODE_W-1:0] rst_code;
  logic [NUM_CH-1:0][CODE_W-1:0] in_regs;

  dac_frame_decode #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dec (
    .frame_valid (frame_valid),
    .frame_word  (frame_word),
    .dec         (dec),
    .sel         (sel),
    .data        (data)
  );

  // named events for the checker
  assign ldac_fall    = ldac_q && !ldac_n;
  assign frame_hit    = |dec;
  assign soft_rst_evt = dec.srst;
  assign rst_code     = reset_code(rst_mid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldac_q    <= 1'b1;
      mask_q    <= '0;
      ref_en    <= 1'b1;
      frame_ack <= 1'b0;
    end else begin
      ldac_q    <= ldac_n;
      frame_ack <= frame_hit;
      if (soft_rst_evt) begin
        mask_q <= '0;
        ref_en <= 1'b1;
      end else begin
        if (dec.mask) mask_q <= data[NUM_CH-1:0];
        if (dec.refc) ref_en <= !data[0];
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dac_chan_slot #(.CODE_W(CODE_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_code  (rst_code),
      .srst      (soft_rst_evt),
      .sel       (sel[i]),
      .wr_in     (dec.wr_in),
      .upd       (dec.upd),
      .wr_upd    (dec.wr_upd),
      .pwr       (dec.pwr),
      .pd_bits   (data[2*i +: 2]),
      .data      (data),
      .masked    (mask_q[i]),
      .ldac_low  (!ldac_n),
      .ldac_fall (ldac_fall),
      .in_q      (in_regs[i]),
      .dac_q     (dac_code[i]),
      .pd_q      (pd_mode[i])
    );
  end

endmodule

// File: rtl/dac_cmd_bank_chk.sv
module dac_cmd_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 16,
  localparam int FRAME_W = 4 + NUM_CH + CODE_W
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          rst_mid,
  input logic                          frame_valid,
  input logic [FRAME_W-1:0]            frame_word,
  input logic                          frame_ack,
  input logic [NUM_CH-1:0][CODE_W-1:0] dac_code,
  input logic [NUM_CH-1:0][1:0]        pd_mode,
  input logic                          ref_en,
  input logic                          ldac_fall
);

  logic [3:0] cmd;
  logic       cmd_ok;
  assign cmd    = frame_word[FRAME_W-1 -: 4];
  assign cmd_ok = (cmd != 4'h0) && !cmd[3];

  // R11
  p_ack_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && cmd_ok |=> frame_ack);

  // R11
  p_ack_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && cmd_ok) |=> !frame_ack);

  // R2
  p_reserved_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && !cmd_ok && !ldac_fall
      |=> $stable(dac_code) && $stable(pd_mode) && $stable(ref_en));

  // R6
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid && !ldac_fall |=> $stable(dac_code));

  // R5
  p_wr_upd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && cmd == 4'h3 && frame_word[CODE_W]
      |=> dac_code[0] == $past(frame_word[CODE_W-1:0]));

  // R9
  p_ref_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && cmd == 4'h7 |=> ref_en == !$past(frame_word[0]));

  // R10
  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && cmd == 4'h6
      |=> ref_en && pd_mode == '0
          && dac_code[NUM_CH-1][CODE_W-1] == $past(rst_mid)
          && dac_code[NUM_CH-1][CODE_W-2:0] == '0);

endmodule

bind dac_cmd_bank dac_cmd_bank_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_mid     (rst_mid),
  .frame_valid (frame_valid),
  .frame_word  (frame_word),
  .frame_ack   (frame_ack),
  .dac_code    (dac_code),
  .pd_mode     (pd_mode),
  .ref_en      (ref_en),
  .ldac_fall   (ldac_fall)
);

// File: tb/tb_dac_cmd_bank.sv
`timescale 1ns/1ps
module tb_dac_cmd_bank;
  localparam int NUM_CH = 4;
  localparam int CODE_W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, rst_mid, frame_valid, ldac_n;
  logic [23:0] frame_word;
  logic        frame_ack, ref_en;
  logic [NUM_CH-1:0][CODE_W-1:0] dac_code;
  logic [NUM_CH-1:0][1:0]        pd_mode;

  dac_cmd_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) dut (
    .clk(clk), .rst_n(rst_n), .rst_mid(rst_mid), .frame_valid(frame_valid),
    .frame_word(frame_word), .ldac_n(ldac_n), .frame_ack(frame_ack),
    .dac_code(dac_code), .pd_mode(pd_mode), .ref_en(ref_en)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model
  logic [15:0] m_in  [NUM_CH];
  logic [15:0] m_dac [NUM_CH];
  logic [1:0]  m_pd  [NUM_CH];
  logic [3:0]  m_mask;
  logic        m_ref, m_ack, m_ldac;

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk(input string tag);
    for (int i = 0; i < NUM_CH; i++) begin
      cmp(tag, $sformatf("dac_code[%0d]", i), int'(dac_code[i]), int'(m_dac[i]));
      cmp(tag, $sformatf("pd_mode[%0d]", i), int'(pd_mode[i]), int'(m_pd[i]));
    end
    cmp(tag, "ref_en", int'(ref_en), int'(m_ref));
    cmp("R11", "frame_ack", int'(frame_ack), int'(m_ack));
    m_ack = 1'b0;
  endtask

  task automatic model_reset(input logic mid);
    for (int i = 0; i < NUM_CH; i++) begin
      m_in[i]  = mid ? 16'd32768 : 16'd0;
      m_dac[i] = m_in[i];
      m_pd[i]  = 2'd0;
    end
    m_mask = 4'd0;
    m_ref  = 1'b1;
  endtask

  function automatic string tag_of(input int c);
    case (c)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R8";
      5: return "R7";
      6: return "R10";
      7: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic frame(input int c, input logic [3:0] s, input logic [15:0] d, input string tag);
    for (int i = 0; i < NUM_CH; i++) begin
      if (s[i]) begin
        if (c == 1) begin
          m_in[i] = d;
          if (!m_ldac && !m_mask[i]) m_dac[i] = d;
        end
        if (c == 2) m_dac[i] = m_in[i];
        if (c == 3) begin m_in[i] = d; m_dac[i] = d; end
        if (c == 4) m_pd[i] = (d >> (2 * i)) & 16'd3;
      end
    end
    if (c == 5) m_mask = d[3:0];
    if (c == 6) model_reset(rst_mid);
    if (c == 7) m_ref = ~d[0];
    m_ack = (c >= 1 && c <= 7);
    @(negedge clk);
    frame_valid = 1'b1;
    frame_word  = {4'(c), s, d};
    @(negedge clk);
    frame_valid = 1'b0;
    chk(tag);
  endtask

  task automatic set_ldac(input logic v);
    @(negedge clk);
    ldac_n = v;
    if (m_ldac && !v)
      for (int i = 0; i < NUM_CH; i++) if (!m_mask[i]) m_dac[i] = m_in[i];
    m_ldac = v;
    @(negedge clk);
    chk("R6");
  endtask

  task automatic hw_reset(input logic mid);
    @(negedge clk);
    rst_n = 1'b0; rst_mid = mid; ldac_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset(mid);
    m_ldac = 1'b1;
    m_ack  = 1'b0;
    chk("R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rst_mid = 1'b0; frame_valid = 1'b0; frame_word = '0; ldac_n = 1'b1;
    m_ack = 1'b0; m_ldac = 1'b1;
    model_reset(1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R10");                         // zero-code reset state
    hw_reset(1'b1);                     // midscale reset state (R10)

    // R3: staged write holds while strobe high, then strobe edge copies (R6)
    frame(1, 4'b0001, 16'h1234, "R3");
    set_ldac(1'b0);
    frame(1, 4'b0010, 16'h5555, "R3"); // write-through with strobe low
    set_ldac(1'b1);

    // R7: mask channels B and D
    frame(5, 4'b0000, 16'h000A, "R7");
    frame(1, 4'b1111, 16'hBEEF, "R7");
    set_ldac(1'b0);                     // only A and C move
    frame(1, 4'b1111, 16'h0101, "R7"); // write-through skips B and D
    set_ldac(1'b1);
    frame(2, 4'b1000, 16'h0000, "R4");
    frame(3, 4'b0101, 16'h7E57, "R1"); // multi-channel selection
    frame(4, 4'b0110, 16'h00E4, "R8");

    // near-exhaustive sweep: every command with every selection pattern (R1)
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 16; s++) begin
        rst_mid = s[1];
        frame(c, 4'(s), 16'(c * 16'h1357 + s * 16'h0F1D), tag_of(c));
        if (((c * 16 + s) % 7) == 3) set_ldac(!m_ldac);
      end
    end

    hw_reset(1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule